// File: doc/BRIEF.md
# Word-Granular SECDED Data Array with Partial-Write Merge

This block is the data store of a cache. Each aligned 32-bit word is held with its own seven check bits. The code corrects any single flipped bit in a stored word and detects any pair of flipped bits. Requests arrive on a valid/ready handshake. A read returns the whole corrected word one cycle after it is accepted, together with a flag for a corrected single error and a flag for a detected double error. A narrow load picks its byte lanes out of that word.

A write carries a word address, 32 data bits and a 4-bit lane mask. When all four lanes are enabled, the write needs nothing from the old contents, so the word is encoded and stored in the cycle it is accepted. When only some lanes are enabled, the old check bits cannot be updated piecemeal. The block then runs a read-merge-encode-write sequence and holds ready low for one extra cycle. During that cycle the old word is decoded and corrected, the enabled lanes replace its bytes, fresh check bits are computed and the result is written back. No other request can enter between the read and the write-back.

A test input XORs a chosen pattern into the codeword of the word being stored, so that stored bit errors can be created on purpose.

Top module: `secdedWordArray`

## Requirements
- R1: A write with all four mask bits set is stored in its acceptance cycle, and reqReady stays high in the following cycle. A later read of that address returns the written data with both error flags low.
- R2: A write with at least one mask bit clear drives reqReady low for exactly the one cycle after acceptance. reqReady is high again in the cycle after that.
- R3: A partial write replaces only the byte lanes whose mask bit is set: mask bit i selects data bits [8i+7:8i]. The other lanes keep their previous values.
- R4: A read accepted at a clock edge gives rspValid high for exactly one cycle, the cycle after that edge, with the word on rspData. Writes never raise rspValid.
- R5: If exactly one bit of a stored 39-bit codeword differs from the correct encoding, a read returns the original data with rspSingleErr=1 and rspDoubleErr=0.
- R6: If exactly two bits of a stored codeword are flipped, a read gives rspDoubleErr=1 and rspSingleErr=0.
- R7: If the old word read by a partial write holds a single-bit error, the corrected old bytes are merged. A later read returns the merged word with both flags low.
- R8: If the old word read by a partial write holds a double-bit error, the write still completes. mergeDoubleErr is high during the stall cycle, and the enabled lanes read back with their new values and both flags low.
- R9: While a partial write is in progress, a request held on the inputs is not accepted. It is accepted at the first edge after reqReady returns high, and a read of the same word returns the merged value.
- R10: After reset, reqReady is high and both rspValid and mergeDoubleErr are low.
- R11: injectFlip is XORed into the codeword stored by a full write in its acceptance cycle. For a partial write, the pattern present at acceptance is applied at the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (6) | Word address |
| reqData | input | 32 | Write data |
| reqMask | input | 4 | Byte-lane enables; bit i covers data bits [8i+7:8i] |
| injectFlip | input | 39 | Test pattern XORed into the stored codeword |
| rspValid | output | 1 | Read response valid |
| rspData | output | 32 | Corrected read data |
| rspSingleErr | output | 1 | A single-bit error was corrected in this response |
| rspDoubleErr | output | 1 | An uncorrectable double-bit error was found in this response |
| mergeDoubleErr | output | 1 | High during a partial-write stall whose old word had a double error |

## Verification
Every one of the 39 codeword positions gets a single flip in turn. An error in the syndrome-to-position mapping or in the overall parity bit would show up as wrong data or a wrong flag on at least one of them. Several flip pairs, including pairs that involve the overall parity bit, check that double errors are not miscorrected and reported as singles. Partial writes are run with lane patterns at both ends of the word, over a clean old word, over one with a single error and over one with a double error. A design that skipped the read, merged the raw uncorrected bytes or dropped the write on a double error would read back wrong bytes or a stale error flag. A read held on the inputs during the stall checks that the request is neither taken early nor lost, and that it sees the merged word.

// File: rtl/secdedPkg.sv
package secdedPkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int PAR_N  = 6;                 // Hamming position bits
  localparam int CHK_W  = PAR_N + 1;         // plus overall parity
  localparam int CODE_W = DATA_W + CHK_W;

  typedef struct packed {
    logic ramRead;       // read old word / latch request
    logic writeDirect;   // full-word write from request inputs
    logic writeMerged;   // write back merged word
  } ctrlStrobes_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              double;
  } decodeRes_t;

  // Codeword bit 0 is the overall parity; bits 1..CODE_W-1 are Hamming
  // positions, with check bits at powers of two.
  function automatic logic [CODE_W-1:0] secdedEncode(logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < PAR_N; i++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p < CODE_W; p++)
        if ((p & (1 << i)) != 0) par ^= c[p];
      c[1 << i] = par;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic decodeRes_t secdedDecode(logic [CODE_W-1:0] cw);
    logic [CODE_W-1:0] c;
    logic [PAR_N-1:0]  syn;
    logic              overall;
    decodeRes_t        r;
    int k;
    c = cw;
    syn = '0;
    for (int p = 1; p < CODE_W; p++)
      if (c[p]) syn ^= PAR_N'(p);
    overall = ^c;
    r.single = 1'b0;
    r.double = 1'b0;
    if (overall) begin
      if (int'(syn) < CODE_W) begin
        r.single = 1'b1;
        c[syn] = ~c[syn];
      end else begin
        r.double = 1'b1;
      end
    end else if (syn != '0) begin
      r.double = 1'b1;
    end
    r.data = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[k] = c[p];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/eccControl.sv
module eccControl
  import secdedPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic         reqReady,
  output logic         rspValid,
  output ctrlStrobes_t strb
);
  typedef enum logic {ST_IDLE, ST_MERGE} state_t;
  state_t state;
  logic   accept;
  logic   fullMask;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign fullMask = &reqMask;

  always_comb begin
    strb.ramRead     = accept && (!reqWrite || !fullMask);
    strb.writeDirect = accept && reqWrite && fullMask;
    strb.writeMerged = (state == ST_MERGE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      rspValid <= accept && !reqWrite;
      if (accept && reqWrite && !fullMask) state <= ST_MERGE;
      else if (state == ST_MERGE)          state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import secdedPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LANES-1:0]  reqMask,
  input  logic [CODE_W-1:0] injectFlip,
  output decodeRes_t        rdRes
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] mem [DEPTH];
  logic [CODE_W-1:0] rdCode;
  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latData;
  logic [LANES-1:0]  latMask;
  logic [CODE_W-1:0] latInject;
  logic [DATA_W-1:0] mergedWord;

  assign rdRes = secdedDecode(rdCode);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[8*g +: 8] = latMask[g] ? latData[8*g +: 8]
                                             : rdRes.data[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (strb.ramRead) begin
      rdCode    <= mem[reqAddr];
      latAddr   <= reqAddr;
      latData   <= reqData;
      latMask   <= reqMask;
      latInject <= injectFlip;
    end
    if (strb.writeDirect)
      mem[reqAddr] <= secdedEncode(reqData) ^ injectFlip;
    else if (strb.writeMerged)
      mem[latAddr] <= secdedEncode(mergedWord) ^ latInject;
  end
endmodule

// File: rtl/secdedWordArray.sv
module secdedWordArray
  import secdedPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  input  logic [3:0]        reqMask,
  input  logic [38:0]       injectFlip,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspSingleErr,
  output logic              rspDoubleErr,
  output logic              mergeDoubleErr
);
  ctrlStrobes_t strb;
  decodeRes_t   rdRes;
  logic         rspValidInt;

  eccControl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqReady(reqReady), .rspValid(rspValidInt),
    .strb(strb)
  );

  eccDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .strb(strb), .reqAddr(reqAddr), .reqData(reqData),
    .reqMask(reqMask), .injectFlip(injectFlip), .rdRes(rdRes)
  );

  assign rspValid       = rspValidInt;
  assign rspData        = rdRes.data;
  assign rspSingleErr   = rspValidInt && rdRes.single;
  assign rspDoubleErr   = rspValidInt && rdRes.double;
  assign mergeDoubleErr = strb.writeMerged && rdRes.double;
endmodule

// File: rtl/secdedWordArrayChecker.sv
module secdedWordArrayChecker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       reqWrite,
  input logic [3:0] reqMask,
  input logic       rspValid,
  input logic       rspSingleErr,
  input logic       rspDoubleErr,
  input logic       mergeDoubleErr
);
  assert_full_no_stall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && (&reqMask)) |=> reqReady);

  assert_partial_stalls_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && !(&reqMask)) |=> !reqReady);

  assert_stall_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> reqReady);

  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  assert_write_no_rsp_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> !rspValid);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rspSingleErr && rspDoubleErr));

  assert_merge_err_in_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    mergeDoubleErr |-> !reqReady);
endmodule

bind secdedWordArray secdedWordArrayChecker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqMask(reqMask), .rspValid(rspValid),
  .rspSingleErr(rspSingleErr), .rspDoubleErr(rspDoubleErr),
  .mergeDoubleErr(mergeDoubleErr)
);

// File: tb/secdedWordArray_test.sv
module secdedWordArray_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [5:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [3:0]  reqMask = '0;
  logic [38:0] injectFlip = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspSingleErr;
  logic        rspDoubleErr;
  logic        mergeDoubleErr;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;   // 125 MHz

  secdedWordArray uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData),
    .reqMask(reqMask), .injectFlip(injectFlip), .rspValid(rspValid),
    .rspData(rspData), .rspSingleErr(rspSingleErr),
    .rspDoubleErr(rspDoubleErr), .mergeDoubleErr(mergeDoubleErr)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mergeExp(logic [31:0] oldW, logic [31:0] newW,
                                           logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = m[i] ? newW[8*i +: 8] : oldW[8*i +: 8];
    return r;
  endfunction

  // One write; checks stall behaviour (R1/R2) and merge error (R8).
  task automatic doWrite(input logic [5:0] a, input logic [31:0] d,
                         input logic [3:0] m, input logic [38:0] inj,
                         input bit expMergeErr, input string tag);
    @(negedge clk);
    check(reqReady == 1'b1, {tag, " R2 ready before write"}, 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqData = d;
    reqMask = m; injectFlip = inj;
    @(negedge clk);
    reqValid = 1'b0; injectFlip = '0;
    check(rspValid == 1'b0, {tag, " R4 no rsp for write"}, 64'(rspValid), 64'd0);
    if (&m) begin
      check(reqReady == 1'b1, {tag, " R1 no stall"}, 64'(reqReady), 64'd1);
    end else begin
      check(reqReady == 1'b0, {tag, " R2 stall"}, 64'(reqReady), 64'd0);
      check(mergeDoubleErr == expMergeErr, {tag, " R8 mergeDoubleErr"},
            64'(mergeDoubleErr), 64'(expMergeErr));
      @(negedge clk);
      check(reqReady == 1'b1, {tag, " R2 ready back"}, 64'(reqReady), 64'd1);
      check(mergeDoubleErr == 1'b0, {tag, " R8 err pulse ends"},
            64'(mergeDoubleErr), 64'd0);
    end
  endtask

  task automatic doRead(input logic [5:0] a, input logic [31:0] expD,
                        input logic [31:0] careMask, input bit expS,
                        input bit expDbl, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, {tag, " R4 rspValid"}, 64'(rspValid), 64'd1);
    check((rspData & careMask) == (expD & careMask), {tag, " data"},
          64'(rspData & careMask), 64'(expD & careMask));
    check(rspSingleErr == expS, {tag, " single flag"}, 64'(rspSingleErr), 64'(expS));
    check(rspDoubleErr == expDbl, {tag, " double flag"}, 64'(rspDoubleErr), 64'(expDbl));
    @(negedge clk);
    check(rspValid == 1'b0, {tag, " R4 one-cycle rsp"}, 64'(rspValid), 64'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(reqReady == 1'b1, "R10 ready after reset", 64'(reqReady), 64'd1);
    check(rspValid == 1'b0, "R10 rspValid after reset", 64'(rspValid), 64'd0);
    check(mergeDoubleErr == 1'b0, "R10 mergeDoubleErr after reset",
          64'(mergeDoubleErr), 64'd0);
  endtask

  task automatic testFullWrites();
    doWrite(6'd1, 32'hDEADBEEF, 4'hF, '0, 1'b0, "R1 w1");
    doWrite(6'd2, 32'h00000000, 4'hF, '0, 1'b0, "R1 w2");
    doWrite(6'd63, 32'hFFFFFFFF, 4'hF, '0, 1'b0, "R1 w63");
    doRead(6'd1, 32'hDEADBEEF, '1, 1'b0, 1'b0, "R1 r1");
    doRead(6'd2, 32'h00000000, '1, 1'b0, 1'b0, "R1 r2");
    doRead(6'd63, 32'hFFFFFFFF, '1, 1'b0, 1'b0, "R1 r63");
  endtask

  task automatic testPartialMerge();
    doWrite(6'd5, 32'h11223344, 4'hF, '0, 1'b0, "R3 init");
    doWrite(6'd5, 32'hAABBCCDD, 4'b0001, '0, 1'b0, "R3 lane0");
    doRead(6'd5, 32'h112233DD, '1, 1'b0, 1'b0, "R3 after lane0");
    doWrite(6'd5, 32'h99887766, 4'b1000, '0, 1'b0, "R3 lane3");
    doRead(6'd5, 32'h992233DD, '1, 1'b0, 1'b0, "R3 after lane3");
    doWrite(6'd5, 32'h0F0F0F0F, 4'b0110, '0, 1'b0, "R3 lanes12");
    doRead(6'd5, 32'h990F0FDD, '1, 1'b0, 1'b0, "R3 after lanes12");
    doWrite(6'd5, 32'h12345678, 4'b0000, '0, 1'b0, "R3 mask0");
    doRead(6'd5, 32'h990F0FDD, '1, 1'b0, 1'b0, "R3 mask0 keeps");
  endtask

  task automatic testSingleErrors();
    logic [31:0] d;
    for (int b = 0; b < 39; b++) begin
      d = 32'hA5C3_0000 ^ (32'h0001_0203 * b);
      doWrite(6'd10, d, 4'hF, 39'd1 << b, 1'b0, "R11 inject single");
      doRead(6'd10, d, '1, 1'b1, 1'b0, $sformatf("R5 bit%0d", b));
    end
  endtask

  task automatic testDoubleErrors();
    int pa [5] = '{0, 1, 3, 20, 37};
    int pb [5] = '{1, 38, 5, 21, 0};
    for (int i = 0; i < 5; i++) begin
      doWrite(6'd11, 32'h5A5A1234, 4'hF, (39'd1 << pa[i]) | (39'd1 << pb[i]),
              1'b0, "R11 inject double");
      doRead(6'd11, 32'h0, '0, 1'b0, 1'b1, $sformatf("R6 pair%0d", i));
    end
  endtask

  task automatic testMergeOverSingle();
    doWrite(6'd20, 32'hCAFEF00D, 4'hF, 39'd1 << 13, 1'b0, "R7 init");
    doWrite(6'd20, 32'h000000AB, 4'b0001, '0, 1'b0, "R7 merge");
    doRead(6'd20, 32'hCAFEF0AB, '1, 1'b0, 1'b0, "R7 corrected merge");
  endtask

  task automatic testMergeOverDouble();
    doWrite(6'd21, 32'h13579BDF, 4'hF, (39'd1 << 4) | (39'd1 << 30), 1'b0, "R8 init");
    doWrite(6'd21, 32'hEEDD0000, 4'b1100, '0, 1'b1, "R8 merge");
    doRead(6'd21, 32'hEEDD0000, 32'hFFFF0000, 1'b0, 1'b0, "R8 new lanes");
  endtask

  task automatic testInjectOnMerge();
    doWrite(6'd22, 32'h01020304, 4'hF, '0, 1'b0, "R11 init");
    doWrite(6'd22, 32'h0000FF00, 4'b0010, 39'd1 << 25, 1'b0, "R11 partial inj");
    doRead(6'd22, 32'h0102FF04, '1, 1'b1, 1'b0, "R11 inject at writeback");
  endtask

  task automatic testAtomicHold();
    doWrite(6'd30, 32'h44332211, 4'hF, '0, 1'b0, "R9 init");
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 6'd30;
    reqData = 32'h00BB0000; reqMask = 4'b0100;
    @(negedge clk);
    reqWrite = 1'b0;   // read of same word held during stall
    check(reqReady == 1'b0, "R9 stall blocks", 64'(reqReady), 64'd0);
    @(negedge clk);
    check(reqReady == 1'b1, "R9 ready returns", 64'(reqReady), 64'd1);
    check(rspValid == 1'b0, "R9 not accepted in stall", 64'(rspValid), 64'd0);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, "R9 held read accepted", 64'(rspValid), 64'd1);
    check(rspData == 32'h44BB2211, "R9 sees merged word",
          64'(rspData), 64'h44BB2211);
    @(negedge clk);
    check(rspValid == 1'b0, "R9 single response", 64'(rspValid), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFullWrites();
    testPartialMerge();
    testSingleErrors();
    testDoubleErrors();
    testMergeOverSingle();
    testMergeOverDouble();
    testInjectOnMerge();
    testAtomicHold();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule